// File: doc/BRIEF.md
# Control Register Write Unit

This block owns the processor's mode-control registers: the machine-control word (CR0), the page-table base (CR3) and the extension-control word (CR4). It also owns the hidden flags the rest of the core reads instead of decoding those registers again. The core presents one write per cycle as a strobe, a two-bit register select and a 32-bit value. The unit stores the value, with fixed bits forced and unsupported bits masked. It then recomputes the hidden protected-mode, address-segment, coprocessor (MP, EM, TS) and fast-save-enable flags.

The unit also tracks whether 64-bit long mode is active. Turning paging on while the long-mode-enable input is set enters long mode, but only if physical-address extension (CR4 bit 5) is already on. Otherwise the whole write is dropped, so that the exception logic elsewhere can report it. Turning paging off while long mode is active leaves long mode and clears the 64-bit code-segment flag. It also pulses a request to cut the instruction pointer to 32 bits. The segment-load logic sets the 64-bit code-segment flag through a load strobe.

Any write that changes how addresses translate raises a single-cycle translation-cache flush request.

Top module: `crw_top`

## Requirements
- R1: After synchronous reset the outputs are: CR0 = 0x60000010, CR3 = 0, CR4 = 0, long-mode-active 0, 64-bit code flag 0, protected-mode 0, address-segment 1, MP/EM/TS 0, fast-save flag 0, flush 0, pointer-truncate 0.
- R2: CR0 bit 4 always reads as 1, whatever value is written.
- R3: An accepted CR0 write pulses the flush request exactly when it changes bit 31 (paging), bit 16 (write protect) or bit 0 (protection enable). A CR0 write that changes only other bits does not pulse it.
- R4: A CR0 write that sets bit 31 while the stored bit 31 is 0, with long-mode-enable high and CR4 bit 5 set, sets long-mode-active.
- R5: The same paging-on write with CR4 bit 5 clear is discarded. CR0, all hidden flags and long-mode-active stay unchanged, and no flush is pulsed.
- R6: A CR0 write that clears bit 31 while long-mode-active is set clears long-mode-active and the 64-bit code flag, and pulses the pointer-truncate output for one cycle.
- R7: The protected-mode flag equals CR0 bit 0. A CR0 write with bit 0 clear forces address-segment to 1. The address-segment clear input takes effect only while bit 0 is set.
- R8: Every accepted CR0 write copies bits 1, 2 and 3 into the MP, EM and TS flags.
- R9: A CR4 write pulses the flush request exactly when it changes bit 7, bit 5 or bit 4.
- R10: With the SSE strap low, CR4 bit 9 is stored as 0 whatever value is written. The fast-save flag always equals the stored CR4 bit 9.
- R11: A CR3 write stores the value. It pulses the flush request only if CR0 bit 31 is set.
- R12: Register select encoding is 0 = CR0, 1 = CR3, 2 = CR4; select 3 is ignored. Updates appear after the clock edge that samples the strobe. The flush pulse is high for that one following cycle only.
- R13: The code-segment load strobe sets the 64-bit code flag to the supplied bit only while long mode is active; otherwise it loads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 CR0, 1 CR3, 2 CR4, 3 none) |
| wr_data | input | 32 | Write value |
| lme | input | 1 | Long-mode enable from the extended-feature register |
| sse_ok | input | 1 | Strap: SSE supported |
| cs_ld | input | 1 | Code-segment load strobe |
| cs_l | input | 1 | Long attribute of the loaded code segment |
| addseg_clr | input | 1 | Clear request for the address-segment flag |
| cr0_o | output | 32 | Stored CR0 |
| cr3_o | output | 32 | Stored CR3 |
| cr4_o | output | 32 | Stored CR4 |
| lma_o | output | 1 | Long mode active |
| cs64_o | output | 1 | 64-bit code segment |
| pe_o | output | 1 | Hidden protected-mode flag |
| addseg_o | output | 1 | Hidden address-segment flag |
| mp_o | output | 1 | Hidden MP flag |
| em_o | output | 1 | Hidden EM flag |
| ts_o | output | 1 | Hidden TS flag |
| osfxsr_o | output | 1 | Hidden fast-save-enable flag |
| tlb_flush_o | output | 1 | One-cycle translation-cache flush request |
| ip_trunc_o | output | 1 | One-cycle instruction-pointer truncate request |

## Verification
The bench sweeps every old/new combination of the three translation-relevant CR0 bits and of the three CR4 bits. A design that compared the wrong mask would flush on harmless writes or miss required flushes. The long-mode sequence tries paging-on first with address extension off. A unit that did not drop the write would set long-mode-active or change CR0. The exit path checks the truncate pulse and the cleared code flag. CR3 writes with paging off and select value 3 catch flushes or updates that should not happen.

// File: rtl/crw_pkg.sv
package crw_pkg;

    localparam int XLEN = 32;

    // CR0 bit positions
    localparam int C0_PE = 0;
    localparam int C0_MP = 1;
    localparam int C0_EM = 2;
    localparam int C0_TS = 3;
    localparam int C0_ET = 4;
    localparam int C0_WP = 16;
    localparam int C0_PG = 31;

    // CR4 bit positions
    localparam int C4_PSE = 4;
    localparam int C4_PAE = 5;
    localparam int C4_PGE = 7;
    localparam int C4_FXS = 9;

    localparam logic [XLEN-1:0] CR0_RESET = 32'h6000_0010;
    localparam logic [XLEN-1:0] CR0_XLATE_MASK =
        (XLEN'(1) << C0_PG) | (XLEN'(1) << C0_WP) | (XLEN'(1) << C0_PE);
    localparam logic [XLEN-1:0] CR4_XLATE_MASK =
        (XLEN'(1) << C4_PGE) | (XLEN'(1) << C4_PAE) | (XLEN'(1) << C4_PSE);

    typedef enum logic [1:0] {
        SEL_CR0  = 2'd0,
        SEL_CR3  = 2'd1,
        SEL_CR4  = 2'd2,
        SEL_NONE = 2'd3
    } cr_sel_e;

    typedef struct packed {
        logic pe;
        logic addseg;
        logic mp;
        logic em;
        logic ts;
        logic osfxsr;
    } hidden_t;

    typedef struct packed {
        logic lma;
        logic cs64;
    } lmode_t;

    typedef struct packed {
        logic accept;
        logic enter;
        logic leave;
        logic flush;
    } cr0_dec_t;

    function automatic logic xlate_changed(input logic [XLEN-1:0] a,
                                           input logic [XLEN-1:0] b,
                                           input logic [XLEN-1:0] mask);
        return |((a ^ b) & mask);
    endfunction

endpackage

// File: rtl/crw_cr0_next.sv
module crw_cr0_next
    import crw_pkg::*;
#(
    parameter int W = crw_pkg::XLEN
) (
    input  logic [W-1:0] cur_cr0,
    input  logic [W-1:0] wdata,
    input  logic         lme,
    input  logic         lma,
    input  logic         pae,
    output logic [W-1:0] nxt_cr0,
    output cr0_dec_t     dec
);
    logic enter_req;

    always_comb begin
        nxt_cr0        = wdata;
        nxt_cr0[C0_ET] = 1'b1;
        enter_req      = !cur_cr0[C0_PG] && nxt_cr0[C0_PG] && lme;
        dec.accept     = !enter_req || pae;
        dec.enter      = enter_req && pae;
        dec.leave      = cur_cr0[C0_PG] && !nxt_cr0[C0_PG] && lma;
        dec.flush      = dec.accept &&
                         xlate_changed(cur_cr0, nxt_cr0, W'(CR0_XLATE_MASK));
    end
endmodule

// File: rtl/crw_cr4_next.sv
module crw_cr4_next
    import crw_pkg::*;
#(
    parameter int W = crw_pkg::XLEN
) (
    input  logic [W-1:0] cur_cr4,
    input  logic [W-1:0] wdata,
    input  logic         sse_ok,
    output logic [W-1:0] nxt_cr4,
    output logic         flush
);
    always_comb begin
        nxt_cr4 = wdata;
        if (!sse_ok) nxt_cr4[C4_FXS] = 1'b0;
        flush = xlate_changed(cur_cr4, nxt_cr4, W'(CR4_XLATE_MASK));
    end
endmodule

// File: rtl/crw_mode_track.sv
module crw_mode_track
    import crw_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cr0_wr,
    input  cr0_dec_t dec,
    input  logic     cs_ld,
    input  logic     cs_l,
    output lmode_t   mode,
    output logic     ip_trunc
);
    logic go_in, go_out;

    assign go_in  = cr0_wr && dec.accept && dec.enter;
    assign go_out = cr0_wr && dec.accept && dec.leave;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode     <= '0;
            ip_trunc <= 1'b0;
        end else begin
            ip_trunc <= go_out;
            if (go_in)       mode.lma <= 1'b1;
            else if (go_out) mode.lma <= 1'b0;
            if (go_out)      mode.cs64 <= 1'b0;
            else if (cs_ld)  mode.cs64 <= cs_l && mode.lma;
        end
    end

    AST_CS64_NEEDS_LMA: assert property (@(posedge clk) disable iff (rst)
        mode.cs64 |-> mode.lma); // R13
    AST_EXIT_CLEANUP: assert property (@(posedge clk) disable iff (rst)
        $fell(mode.lma) |-> (!mode.cs64 && ip_trunc)); // R6
    AST_TRUNC_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ip_trunc |=> !ip_trunc); // R6
endmodule

// File: rtl/crw_top.sv
module crw_top
    import crw_pkg::*;
#(
    parameter int W = crw_pkg::XLEN
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr_en,
    input  logic [1:0]   wr_sel,
    input  logic [W-1:0] wr_data,
    input  logic         lme,
    input  logic         sse_ok,
    input  logic         cs_ld,
    input  logic         cs_l,
    input  logic         addseg_clr,
    output logic [W-1:0] cr0_o,
    output logic [W-1:0] cr3_o,
    output logic [W-1:0] cr4_o,
    output logic         lma_o,
    output logic         cs64_o,
    output logic         pe_o,
    output logic         addseg_o,
    output logic         mp_o,
    output logic         em_o,
    output logic         ts_o,
    output logic         osfxsr_o,
    output logic         tlb_flush_o,
    output logic         ip_trunc_o
);
    logic [W-1:0] cr0_q, cr3_q, cr4_q;
    logic [W-1:0] cr0_nxt, cr4_nxt;
    hidden_t      hid_q;
    lmode_t       mode;
    cr0_dec_t     c0_dec;
    logic         c4_flush;
    logic         flush_q;
    logic         wr_cr0, wr_cr3, wr_cr4, cr0_take;

    assign wr_cr0   = wr_en && (cr_sel_e'(wr_sel) == SEL_CR0);
    assign wr_cr3   = wr_en && (cr_sel_e'(wr_sel) == SEL_CR3);
    assign wr_cr4   = wr_en && (cr_sel_e'(wr_sel) == SEL_CR4);
    assign cr0_take = wr_cr0 && c0_dec.accept;

    crw_cr0_next #(.W(W)) u_cr0_next (
        .cur_cr0 (cr0_q),
        .wdata   (wr_data),
        .lme     (lme),
        .lma     (mode.lma),
        .pae     (cr4_q[C4_PAE]),
        .nxt_cr0 (cr0_nxt),
        .dec     (c0_dec)
    );

    crw_cr4_next #(.W(W)) u_cr4_next (
        .cur_cr4 (cr4_q),
        .wdata   (wr_data),
        .sse_ok  (sse_ok),
        .nxt_cr4 (cr4_nxt),
        .flush   (c4_flush)
    );

    crw_mode_track u_mode (
        .clk      (clk),
        .rst      (rst),
        .cr0_wr   (wr_cr0),
        .dec      (c0_dec),
        .cs_ld    (cs_ld),
        .cs_l     (cs_l),
        .mode     (mode),
        .ip_trunc (ip_trunc_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cr0_q        <= W'(CR0_RESET);
            cr3_q        <= '0;
            cr4_q        <= '0;
            flush_q      <= 1'b0;
            hid_q.pe     <= CR0_RESET[C0_PE];
            hid_q.addseg <= 1'b1;
            hid_q.mp     <= CR0_RESET[C0_MP];
            hid_q.em     <= CR0_RESET[C0_EM];
            hid_q.ts     <= CR0_RESET[C0_TS];
            hid_q.osfxsr <= 1'b0;
        end else begin
            flush_q <= (wr_cr0 && c0_dec.flush) ||
                       (wr_cr3 && cr0_q[C0_PG]) ||
                       (wr_cr4 && c4_flush);
            if (cr0_take) begin
                cr0_q    <= cr0_nxt;
                hid_q.pe <= cr0_nxt[C0_PE];
                hid_q.mp <= cr0_nxt[C0_MP];
                hid_q.em <= cr0_nxt[C0_EM];
                hid_q.ts <= cr0_nxt[C0_TS];
                if (!cr0_nxt[C0_PE])  hid_q.addseg <= 1'b1;
                else if (addseg_clr)  hid_q.addseg <= 1'b0;
            end else if (addseg_clr && cr0_q[C0_PE]) begin
                hid_q.addseg <= 1'b0;
            end
            if (wr_cr3) cr3_q <= wr_data;
            if (wr_cr4) begin
                cr4_q        <= cr4_nxt;
                hid_q.osfxsr <= cr4_nxt[C4_FXS];
            end
        end
    end

    assign cr0_o       = cr0_q;
    assign cr3_o       = cr3_q;
    assign cr4_o       = cr4_q;
    assign lma_o       = mode.lma;
    assign cs64_o      = mode.cs64;
    assign pe_o        = hid_q.pe;
    assign addseg_o    = hid_q.addseg;
    assign mp_o        = hid_q.mp;
    assign em_o        = hid_q.em;
    assign ts_o        = hid_q.ts;
    assign osfxsr_o    = hid_q.osfxsr;
    assign tlb_flush_o = flush_q;

    AST_ET_STUCK: assert property (@(posedge clk) disable iff (rst)
        cr0_q[C0_ET]); // R2
    AST_PE_MIRROR: assert property (@(posedge clk) disable iff (rst)
        hid_q.pe == cr0_q[C0_PE]); // R7
    AST_ADDSEG_REAL: assert property (@(posedge clk) disable iff (rst)
        !cr0_q[C0_PE] |-> hid_q.addseg); // R7
    AST_LMA_NEEDS_PG: assert property (@(posedge clk) disable iff (rst)
        mode.lma |-> cr0_q[C0_PG]); // R4
    AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (wr_cr0 && !cr0_q[C0_PG] && wr_data[C0_PG] && lme && !cr4_q[C4_PAE])
        |=> ($stable(cr0_q) && !tlb_flush_o && !mode.lma)); // R5
    AST_FXS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        hid_q.osfxsr == cr4_q[C4_FXS]); // R10
    AST_CR3_QUIET: assert property (@(posedge clk) disable iff (rst)
        (wr_cr3 && !cr0_q[C0_PG]) |=> !tlb_flush_o); // R11
    AST_NONE_SEL: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == 2'd3 && !addseg_clr && !cs_ld)
        |=> ($stable(cr0_q) && $stable(cr3_q) && $stable(cr4_q) && !tlb_flush_o)); // R12
endmodule

// File: tb/test_crw_top.sv
`timescale 1ns/1ps
module test_crw_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, lme, sse_ok, cs_ld, cs_l, addseg_clr;
    logic [1:0]  wr_sel;
    logic [31:0] wr_data;
    logic [31:0] cr0_o, cr3_o, cr4_o;
    logic        lma_o, cs64_o, pe_o, addseg_o, mp_o, em_o, ts_o, osfxsr_o;
    logic        tlb_flush_o, ip_trunc_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 0;

    // reference state
    logic [31:0] m_cr0, m_cr3, m_cr4;
    bit          m_lma, m_cs64, m_addseg;

    always #2 clk = ~clk;

    crw_top i_crw_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .lme(lme), .sse_ok(sse_ok), .cs_ld(cs_ld), .cs_l(cs_l),
        .addseg_clr(addseg_clr), .cr0_o(cr0_o), .cr3_o(cr3_o), .cr4_o(cr4_o),
        .lma_o(lma_o), .cs64_o(cs64_o), .pe_o(pe_o), .addseg_o(addseg_o),
        .mp_o(mp_o), .em_o(em_o), .ts_o(ts_o), .osfxsr_o(osfxsr_o),
        .tlb_flush_o(tlb_flush_o), .ip_trunc_o(ip_trunc_o)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req, input bit fl, input bit tr);
        chk(req, "cr0", cr0_o, m_cr0);
        chk(req, "cr3", cr3_o, m_cr3);
        chk(req, "cr4", cr4_o, m_cr4);
        chk(req, "lma", 32'(lma_o), 32'(m_lma));
        chk(req, "cs64", 32'(cs64_o), 32'(m_cs64));
        chk("R7", "pe", 32'(pe_o), 32'(m_cr0[0]));
        chk("R7", "addseg", 32'(addseg_o), 32'(m_addseg));
        chk("R8", "mp/em/ts", {29'd0, ts_o, em_o, mp_o}, {29'd0, m_cr0[3:1]});
        chk("R10", "osfxsr", 32'(osfxsr_o), 32'(m_cr4[9]));
        chk(req, "flush", 32'(tlb_flush_o), 32'(fl));
        chk(req, "trunc", 32'(ip_trunc_o), 32'(tr));
    endtask

    // expected effect of one write, from the requirements
    task automatic model_wr(input logic [1:0] s, input logic [31:0] d,
                            output bit fl, output bit tr);
        logic [31:0] nv;
        bit enter;
        fl = 0; tr = 0;
        case (s)
            2'd0: begin
                nv = d | 32'h10;
                enter = !m_cr0[31] && nv[31] && lme;
                if (!(enter && !m_cr4[5])) begin
                    fl = |((nv ^ m_cr0) & 32'h8001_0001);
                    if (enter) m_lma = 1;
                    if (m_cr0[31] && !nv[31] && m_lma) begin
                        m_lma = 0; m_cs64 = 0; tr = 1;
                    end
                    m_cr0 = nv;
                    if (!nv[0]) m_addseg = 1;
                end
            end
            2'd1: begin m_cr3 = d; fl = m_cr0[31]; end
            2'd2: begin
                nv = sse_ok ? d : (d & ~32'h200);
                fl = |((nv ^ m_cr4) & 32'hB0);
                m_cr4 = nv;
            end
            default: ;
        endcase
    endtask

    task automatic wr(input string req, input logic [1:0] s, input logic [31:0] d);
        bit fl, tr;
        @(negedge clk);
        wr_en = 1; wr_sel = s; wr_data = d;
        @(negedge clk);
        wr_en = 0;
        model_wr(s, d, fl, tr);
        check_state(req, fl, tr);
        @(negedge clk);
        chk("R12", "flush drop", 32'(tlb_flush_o), 0);
        chk("R12", "trunc drop", 32'(ip_trunc_o), 0);
    endtask

    function automatic logic [31:0] mk0(input int k, input int m);
        return (32'(k >> 2 & 1) << 31) | (32'(k >> 1 & 1) << 16) |
               32'(k & 1) | (32'(m & 7) << 1) | (32'(k) << 8);
    endfunction

    function automatic logic [31:0] mk4(input int k, input int f);
        return (32'(k >> 2 & 1) << 7) | (32'(k >> 1 & 1) << 5) |
               (32'(k & 1) << 4) | (32'(f & 1) << 9) | (32'(k) << 12);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1; wr_en = 0; wr_sel = 0; wr_data = 0; lme = 0; sse_ok = 1;
        cs_ld = 0; cs_l = 0; addseg_clr = 0;
        repeat (3) @(negedge clk);
        rst = 0;
        m_cr0 = 32'h6000_0010; m_cr3 = 0; m_cr4 = 0;
        m_lma = 0; m_cs64 = 0; m_addseg = 1;
        @(negedge clk);
        check_state("R1", 0, 0);

        // R2 R3 R8: all old/new combinations of PG, WP, PE
        for (int a = 0; a < 8; a++)
            for (int b = 0; b < 8; b++) begin
                wr("R3", 2'd0, mk0(a, a + 3));
                wr("R2", 2'd0, mk0(b, a + b));
            end

        // R9 R10: CR4 sweeps with both strap values
        for (int st = 0; st < 2; st++) begin
            sse_ok = st[0];
            for (int a = 0; a < 8; a++)
                for (int b = 0; b < 8; b++) begin
                    wr("R9", 2'd2, mk4(a, b));
                    wr("R10", 2'd2, mk4(b, a + 1));
                end
        end
        sse_ok = 1;

        // R11: CR3 with paging off then on
        wr("R11", 2'd0, 32'h0000_0001);
        wr("R11", 2'd1, 32'h1234_5000);
        wr("R11", 2'd0, 32'h8000_0001);
        wr("R11", 2'd1, 32'h0ABC_D000);
        wr("R11", 2'd0, 32'h0000_0001);

        // R12: select 3 ignored
        wr("R12", 2'd3, 32'hFFFF_FFFF);

        // R7: address-segment clear with PE set, then ignored with PE clear
        @(negedge clk); addseg_clr = 1;
        @(negedge clk); addseg_clr = 0; m_addseg = 0;
        chk("R7", "addseg clr", 32'(addseg_o), 0);
        wr("R7", 2'd0, 32'h0000_0000);
        @(negedge clk); addseg_clr = 1;
        @(negedge clk); addseg_clr = 0;
        chk("R7", "addseg held", 32'(addseg_o), 1);

        // R13: code load while long mode is off
        @(negedge clk); cs_ld = 1; cs_l = 1;
        @(negedge clk); cs_ld = 0;
        chk("R13", "cs64 off", 32'(cs64_o), 0);

        // R5: paging on with LME and PAE clear is dropped
        lme = 1;
        wr("R5", 2'd2, 32'h0000_0000);
        wr("R5", 2'd0, 32'h8000_0001);
        // R4: now with PAE
        wr("R4", 2'd2, 32'h0000_0020);
        wr("R4", 2'd0, 32'h8000_0001);
        chk("R4", "lma on", 32'(lma_o), 1);
        @(negedge clk); cs_ld = 1; cs_l = 1;
        @(negedge clk); cs_ld = 0; m_cs64 = 1;
        chk("R13", "cs64 on", 32'(cs64_o), 1);
        // R6: paging off leaves long mode
        wr("R6", 2'd0, 32'h0000_0001);
        chk("R6", "lma off", 32'(lma_o), 0);
        chk("R6", "cs64 off", 32'(cs64_o), 0);
        lme = 0;

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule